// File: doc/BRIEF.md
# Serial Port Register Block

This block is the memory-mapped register file in front of a serial port. Software reaches it over a simple 32-bit read/write bus. It holds a status word, a receive data register, a baud-rate word, three control words and a guard-time/prescaler word. Received bytes arrive on a byte stream with a valid/ready handshake. Bytes to send leave on a byte stream as a single-cycle valid strobe. One level-sensitive interrupt line shows which enabled status flags are currently raised.

The status flags and their interrupt enables sit at the same bit positions. This makes the interrupt condition a bitwise AND of the status word and control word 1. A status write acts in one of two ways, chosen by the written value: a small value loads the flags, and a large value acts as a clear mask. The bit-level serializer, baud generation, parity, framing and DMA are handled elsewhere. The rate, control-2, control-3 and guard words are storage only.

Top module: `usart_csr_top`

## Requirements
- R1: After reset, status reads 0x000000C0. The data, rate, control-1, control-2, control-3 and guard words all read 0. `irq` is 0 and `rxReady` is 1.
- R2: The word at `busAddr[9:2]` selects the register: 0 status, 1 data, 2 rate, 3 control-1, 4 control-2, 5 control-3, 6 guard. Bits [1:0] are ignored. Any other word in the 1 KB window reads 0 and ignores writes. Rate, control-2, control-3 and guard read back the last full 32-bit value written to them.
- R3: A status write with a value of at most 0x3FF loads the 10-bit status with that value and forces bit 7 (transmit-empty) to 1.
- R4: A status write with a value above 0x3FF replaces status with status AND the low 10 bits of the value, so zero bits clear flags (bit 7 included).
- R5: A data write with a value below 0xF000 pulses `txValid` in the same cycle, with `txData` equal to value[7:0]. It also sets status bit 6 (transmission-complete). A data write of 0xF000 or above gives no pulse and changes nothing.
- R6: A byte offered while `rxReady` is 1 is stored only when control-1 bit 13 (global enable) and bit 2 (receiver enable) are both 1. A stored byte sets status bit 5 (receive-not-empty).
- R7: `rxReady` is 1 exactly while status bit 5 is 0. A byte offered while either enable bit is 0 is consumed and dropped, and leaves status and data unchanged.
- R8: A data read returns the stored byte zero-extended and clears status bit 5.
- R9: `irq` is registered. After every clock edge it equals the OR over bits 5, 6 and 7 of (status AND control-1) as just updated.
- R10: Control-1 stores all 32 written bits and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Byte address within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| rxValid | input | 1 | Incoming byte offered |
| rxData | input | 8 | Incoming byte |
| rxReady | output | 1 | Block can take a byte |
| txValid | output | 1 | One-cycle transmit strobe |
| txData | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The status write is swept over every load value from 0 to 0x3FF. The clear mask is swept over every low-10-bit pattern. Together these separate the load path from the AND path and show that the forced transmit-empty bit appears only on a load. The interrupt is tried with all 64 pairings of the three flags and their three enables, which catches a wrong bit position or a missing term. The receive path is tried under all four combinations of the two enable bits and with all 256 byte values, including a second byte offered while the register is full. The transmit path is tried with all byte values and on both sides of the 0xF000 limit.

// File: rtl/usart_csr_pkg.sv
package usart_csr_pkg;
  localparam int STAT_W   = 10;
  localparam int BYTE_W   = 8;
  localparam int RXNE_BIT = 5;
  localparam int TC_BIT   = 6;
  localparam int TXE_BIT  = 7;
  localparam int RXEN_BIT = 2;
  localparam int GEN_BIT  = 13;
  localparam logic [31:0] LOAD_MAX = 32'((1 << STAT_W) - 1);
  localparam logic [31:0] TX_LIMIT = 32'h0000_F000;
  localparam logic [STAT_W-1:0] STAT_RESET =
    STAT_W'((1 << TXE_BIT) | (1 << TC_BIT));
  localparam logic [STAT_W-1:0] IRQ_MASK =
    STAT_W'((1 << TXE_BIT) | (1 << TC_BIT) | (1 << RXNE_BIT));

  typedef enum logic [2:0] {
    SEL_STAT  = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_RATE  = 3'd2,
    SEL_CTL1  = 3'd3,
    SEL_CTL2  = 3'd4,
    SEL_CTL3  = 3'd5,
    SEL_GUARD = 3'd6,
    SEL_NONE  = 3'd7
  } regSel_t;

  typedef struct packed {
    regSel_t sel;
    logic    wrEn;
    logic    rdEn;
    logic    txFire;
    logic    rdPop;
    logic    rxTake;
  } csrStrobes_t;
endpackage

// File: rtl/usart_csr_ctrl.sv
module usart_csr_ctrl
  import usart_csr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxValid,
  input  logic              rxFull,
  input  logic              enGlobal,
  input  logic              enRx,
  output logic              rxReady,
  output csrStrobes_t       strobes
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int NUM_REGS = 7;

  logic [IDX_W-1:0] wordIdx;
  regSel_t sel;

  assign wordIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    if (wordIdx < IDX_W'(NUM_REGS)) sel = regSel_t'(wordIdx[2:0]);
    else                            sel = SEL_NONE;
  end

  assign rxReady = !rxFull;

  always_comb begin
    strobes.sel    = sel;
    strobes.wrEn   = busSel && busWr && (sel != SEL_NONE);
    strobes.rdEn   = busSel && !busWr;
    strobes.txFire = busSel && busWr && (sel == SEL_DATA) &&
                     (32'(busWdata) < TX_LIMIT);
    strobes.rdPop  = busSel && !busWr && (sel == SEL_DATA);
    strobes.rxTake = rxValid && !rxFull && enGlobal && enRx;
  end
endmodule

// File: rtl/usart_csr_dpath.sv
module usart_csr_dpath
  import usart_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  csrStrobes_t         strobes,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [BYTE_W-1:0]   rxData,
  output logic [DATA_W-1:0]   busRdata,
  output logic [STAT_W-1:0]   statusQ,
  output logic [DATA_W-1:0]   ctl1Q,
  output logic [BYTE_W-1:0]   dataQ,
  output logic                irqQ
);
  logic [DATA_W-1:0] rateQ, ctl2Q, ctl3Q, guardQ;
  logic [STAT_W-1:0] statusN;
  logic [DATA_W-1:0] ctl1N;
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    statusN = statusQ;
    ctl1N   = ctl1Q;
    if (strobes.wrEn && strobes.sel == SEL_STAT) begin
      if (32'(busWdata) <= LOAD_MAX)
        statusN = busWdata[STAT_W-1:0] | STAT_W'(1 << TXE_BIT);
      else
        statusN = statusQ & busWdata[STAT_W-1:0];
    end
    if (strobes.wrEn && strobes.sel == SEL_CTL1) ctl1N = busWdata;
    if (strobes.txFire) statusN[TC_BIT]   = 1'b1;
    if (strobes.rdPop)  statusN[RXNE_BIT] = 1'b0;
    if (strobes.rxTake) statusN[RXNE_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= STAT_RESET;
      ctl1Q   <= '0;
      dataQ   <= '0;
      rateQ   <= '0;
      ctl2Q   <= '0;
      ctl3Q   <= '0;
      guardQ  <= '0;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusN;
      ctl1Q   <= ctl1N;
      irqQ    <= |(statusN & ctl1N[STAT_W-1:0] & IRQ_MASK);
      if (strobes.rxTake) dataQ <= rxData;
      if (strobes.wrEn) begin
        case (strobes.sel)
          SEL_RATE:  rateQ  <= busWdata;
          SEL_CTL2:  ctl2Q  <= busWdata;
          SEL_CTL3:  ctl3Q  <= busWdata;
          SEL_GUARD: guardQ <= busWdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (strobes.sel)
      SEL_STAT:  rdMux = DATA_W'(statusQ);
      SEL_DATA:  rdMux = DATA_W'(dataQ);
      SEL_RATE:  rdMux = rateQ;
      SEL_CTL1:  rdMux = ctl1Q;
      SEL_CTL2:  rdMux = ctl2Q;
      SEL_CTL3:  rdMux = ctl3Q;
      SEL_GUARD: rdMux = guardQ;
      default:   rdMux = '0;
    endcase
    busRdata = strobes.rdEn ? rdMux : '0;
  end
endmodule

// File: rtl/usart_csr_top.sv
module usart_csr_top
  import usart_csr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              irq
);
  csrStrobes_t       strobes;
  logic [STAT_W-1:0] statusQ;
  logic [DATA_W-1:0] ctl1Q;
  logic [BYTE_W-1:0] dataQ;

  usart_csr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .rxValid  (rxValid),
    .rxFull   (statusQ[RXNE_BIT]),
    .enGlobal (ctl1Q[GEN_BIT]),
    .enRx     (ctl1Q[RXEN_BIT]),
    .rxReady  (rxReady),
    .strobes  (strobes)
  );

  usart_csr_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWdata (busWdata),
    .rxData   (rxData),
    .busRdata (busRdata),
    .statusQ  (statusQ),
    .ctl1Q    (ctl1Q),
    .dataQ    (dataQ),
    .irqQ     (irq)
  );

  assign txValid = strobes.txFire;
  assign txData  = busWdata[7:0];
endmodule

// File: rtl/usart_csr_chk.sv
module usart_csr_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              rxValid,
  input logic [7:0]        rxData,
  input logic              rxReady,
  input logic              txValid,
  input logic              irq,
  input logic [9:0]        statusQ,
  input logic [DATA_W-1:0] ctl1Q,
  input logic [7:0]        dataQ
);
  AST_RX_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady && ctl1Q[13] && ctl1Q[2]) |=> (statusQ[5] && dataQ == $past(rxData))); // R6

  AST_RX_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !(ctl1Q[13] && ctl1Q[2]) && !busSel) |=> ($stable(dataQ) && $stable(statusQ))); // R7

  AST_TX_SETS_TC: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> statusQ[6]); // R5

  AST_TX_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (busSel && busWr)); // R5

  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr[ADDR_W-1:2] == 1 && !(rxValid && rxReady)) |=> !statusQ[5]); // R8

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    irq == |(statusQ & ctl1Q[9:0] & 10'h0E0)); // R9
endmodule

bind usart_csr_top usart_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .rxValid (rxValid),
  .rxData  (rxData),
  .rxReady (rxReady),
  .txValid (txValid),
  .irq     (irq),
  .statusQ (statusQ),
  .ctl1Q   (ctl1Q),
  .dataQ   (dataQ)
);

// File: tb/test_usart_csr_top.sv
module test_usart_csr_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReady, txValid, irq;
  logic [7:0]  txData;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usart_csr_top i_usart_csr_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [31:0] d,
                          output logic tv, output logic [7:0] td);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    #(CLK_PERIOD/4);
    tv = txValid; td = txData;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    logic tv;
    logic [7:0] td;
    busWrite(a, d, tv, td);
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] q);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #(CLK_PERIOD/4);
    q = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic rxSend(input logic [7:0] b, output logic rdy);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    #(CLK_PERIOD/4);
    rdy = rxReady;
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    logic tv, rdy;
    logic [7:0] td;
    logic [7:0] lastByte;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rxReady", {31'b0, rxReady}, 1);
    rd(10'h000, q); check("R1 status", q, 32'h0000_00C0);
    for (int i = 1; i < 7; i++) begin
      rd(10'(i * 4), q); check("R1 zero reg", q, 0);
    end

    // R2 storage registers, byte bits ignored, unmapped words
    wr(10'h008, 32'hDEAD_BEEF); wr(10'h010, 32'h1234_5678);
    wr(10'h014, 32'h8765_4321); wr(10'h01B, 32'hCAFE_F00D);
    rd(10'h008, q); check("R2 rate", q, 32'hDEAD_BEEF);
    rd(10'h00B, q); check("R2 rate byte addr", q, 32'hDEAD_BEEF);
    rd(10'h010, q); check("R2 ctl2", q, 32'h1234_5678);
    rd(10'h014, q); check("R2 ctl3", q, 32'h8765_4321);
    rd(10'h018, q); check("R2 guard", q, 32'hCAFE_F00D);
    wr(10'h01C, 32'hFFFF_FFFF); wr(10'h3FC, 32'h0000_0000);
    rd(10'h01C, q); check("R2 unmapped 0x1C", q, 0);
    rd(10'h3FC, q); check("R2 unmapped 0x3FC", q, 0);
    rd(10'h200, q); check("R2 unmapped 0x200", q, 0);
    rd(10'h000, q); check("R2 status untouched", q, 32'h0000_00C0);
    rd(10'h00C, q); check("R2 ctl1 untouched", q, 0);

    // R3 load sweep over all small values
    for (int v = 0; v <= 32'h3FF; v++) begin
      wr(10'h000, 32'(v));
      rd(10'h000, q); check("R3 load", q, 32'(v) | 32'h80);
    end

    // R4 clear-mask sweep
    for (int m = 0; m < 1024; m++) begin
      wr(10'h000, 32'h3FF);
      wr(10'h000, 32'hFFFF_FC00 | 32'(m));
      rd(10'h000, q); check("R4 and-mask", q, 32'(m));
    end

    // R5 transmit path
    for (int b = 0; b < 256; b++) begin
      wr(10'h000, 32'h80);
      busWrite(10'h004, 32'h0000_0A00 | 32'(b), tv, td);
      check("R5 txValid", {31'b0, tv}, 1);
      check("R5 txData", {24'b0, td}, 32'(b));
      rd(10'h000, q); check("R5 tc set", q, 32'hC0);
    end
    wr(10'h000, 32'h80);
    busWrite(10'h004, 32'h0000_EFFF, tv, td);
    check("R5 limit-1 tx", {23'b0, tv, td}, 32'h1FF);
    wr(10'h000, 32'h80);
    busWrite(10'h004, 32'h0000_F000, tv, td);
    check("R5 limit ignored tx", {31'b0, tv}, 0);
    busWrite(10'h004, 32'h1234_F0AB, tv, td);
    check("R5 large ignored tx", {31'b0, tv}, 0);
    rd(10'h000, q); check("R5 ignored status", q, 32'h80);

    // R6 / R7 enable combinations
    lastByte = 8'h00;
    for (int e = 0; e < 4; e++) begin
      logic [31:0] ctl;
      logic [7:0] b;
      ctl = (e[1] ? 32'h2000 : 0) | (e[0] ? 32'h4 : 0);
      b = 8'(8'h31 + e);
      wr(10'h00C, ctl);
      wr(10'h000, 32'h80);
      rxSend(b, rdy);
      check("R7 ready when empty", {31'b0, rdy}, 1);
      rd(10'h000, q);
      check("R6 rxne gated", q, (e == 3) ? 32'hA0 : 32'h80);
      if (e == 3) lastByte = b;
      rd(10'h004, q); check("R7 data after gate", q, {24'b0, lastByte});
    end

    // R6 / R7 / R8 all bytes with receiver on
    wr(10'h00C, 32'h2004);
    for (int b = 0; b < 256; b++) begin
      rxSend(8'(b), rdy);
      check("R7 ready before", {31'b0, rdy}, 1);
      check("R7 ready low when full", {31'b0, rxReady}, 0);
      rxSend(8'(~b), rdy);
      check("R7 second byte not ready", {31'b0, rdy}, 0);
      rd(10'h004, q); check("R8 data byte", q, 32'(b));
      rd(10'h000, q); check("R8 rxne cleared", q & 32'h20, 0);
      check("R8 ready again", {31'b0, rxReady}, 1);
    end

    // R9 interrupt: all flag/enable pairings
    for (int s = 0; s < 8; s++) begin
      for (int en = 0; en < 8; en++) begin
        wr(10'h00C, 32'(en) << 5);
        wr(10'h000, 32'h3FF);
        wr(10'h000, 32'hFFFF_FC00 | (32'(s) << 5));
        check("R9 irq", {31'b0, irq}, ((s & en) != 0) ? 1 : 0);
      end
    end
    wr(10'h000, 32'h000);
    wr(10'h00C, 32'h80);
    check("R9 irq on ctl1 write", {31'b0, irq}, 1);
    wr(10'h00C, 32'h0);
    check("R9 irq off", {31'b0, irq}, 0);

    // R10 control-1 full width
    wr(10'h00C, 32'hA5C3_5A3C);
    rd(10'h00C, q); check("R10 ctl1", q, 32'hA5C3_5A3C);
    wr(10'h00C, 32'hFFFF_FFFF);
    rd(10'h00C, q); check("R10 ctl1 ones", q, 32'hFFFF_FFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule